// File: doc/BRIEF.md
# Keyboard Link Host Transmitter

This block sends one command byte from a host controller to a keyboard over a two-wire, open-drain serial link. The keyboard, not the host, drives the bit clock. The host side offers a byte with a valid/ready handshake and gets back either a one-cycle `tx_done` pulse or a one-cycle `tx_error` pulse. The line side takes the sensed levels of the clock and data wires and returns one pull-low enable for each wire. The pads turn these enables into open-drain drivers.

A transfer runs as follows. The host pulls the clock wire low to ask for the link. The keyboard answers by letting the data wire go high. The host then frees the clock. The keyboard holds the clock low for a long start bit and then clocks the frame. On each rising clock edge the host presents the next bit, and the keyboard samples it while the clock is low. The frame is eight data bits, least significant first, then one odd-parity bit. After the parity bit the host frees the data wire and waits for the keyboard to pull it low as the stop acknowledge.

Both wires pass through a synchronizer before any edge is detected. A cycle-count timeout, 2000 system cycles by default (2 ms at 1 MHz), ends any transfer that stalls while it waits for an expected event.

Top module: `kbd_host_tx`

## Requirements
- R1: After reset and whenever no transfer is in progress, `tx_ready` is 1, both pull enables are 0, and `tx_done` and `tx_error` are 0.
- R2: A byte is accepted in a cycle where `tx_valid` and `tx_ready` are both 1. In the next cycle `kb_clk_pull` is 1 and `tx_ready` is 0.
- R3: `kb_clk_pull` stays at 1 until the synchronized data wire makes a low-to-high transition. It is released within 4 system cycles of that transition reaching the input pin.
- R4: Each synchronized rising edge of the clock wire, starting with the one that ends the start bit, presents the next frame bit. A frame bit of 0 sets `kb_data_pull` to 1, and a frame bit of 1 releases it. Data bits go out bit 0 first, and the data pull changes only after a clock rising edge or an abort.
- R5: The ninth frame bit is the odd parity of the byte: the inverse of the XOR of its eight bits.
- R6: The tenth rising clock edge releases the data wire. Once the released wire has been seen high, a low level on it produces exactly one `tx_done` pulse, and the block returns to idle.
- R7: The timer restarts on each expected event. If TIMEOUT_CYCLES system cycles pass without one, `tx_error` pulses for one cycle and both pulls are released in the next cycle. A new transfer can then proceed normally.
- R8: `tx_done` and `tx_error` are single-cycle pulses, and a successful transfer raises no `tx_error`.
- R9: `tx_valid` is ignored while `tx_ready` is 0. The byte being sent is not replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 1 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DATA_W | Command byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block idle and able to accept a byte |
| tx_done | output | 1 | One-cycle pulse when the stop acknowledge is seen |
| tx_error | output | 1 | One-cycle pulse when a transfer is aborted by timeout |
| kb_clk_in | input | 1 | Sensed level of the clock wire (asynchronous) |
| kb_data_in | input | 1 | Sensed level of the data wire (asynchronous) |
| kb_clk_pull | output | 1 | Drive the clock wire low when 1 |
| kb_data_pull | output | 1 | Drive the data wire low when 1 |

## Verification
Some rules are checked by assertions on every cycle. The idle release of both wires is one. Another is the acceptance response, and another is that the clock pull is freed only after a data rise or an abort. The assertions also check that the data pull moves only after a clock rise, and that the done and error pulses each last one cycle and leave the lines released.

Other behaviour can only be shown by the bench's scenarios, which run a keyboard model against the block. These scenarios cover the bit order and parity value that a keyboard actually samples, the request latency, and the stop handshake for frames that end in parity 0 and parity 1. They also cover the timeout window, both with no answer and with a stall in mid-frame, recovery after an abort, and a byte offered while the block is busy.

// File: rtl/kbd_tx_pkg.sv
package kbd_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ      = 3'd1,
    ST_START    = 3'd2,
    ST_BITS     = 3'd3,
    ST_STOP_REL = 3'd4,
    ST_STOP_ACK = 3'd5
  } tx_state_e;

  // Lane positions inside the synchronizer vector
  localparam int LANE_CLK = 0;
  localparam int LANE_DAT = 1;
  localparam int LANES    = 2;

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
      logic [STAGES-1:0] chain;
      logic              prev;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
          prev  <= 1'b0;
        end else begin
          chain <= {chain[STAGES-2:0], async_in[g]};
          prev  <= chain[STAGES-1];
        end
      end

      assign level[g] = chain[STAGES-1];
      assign rise[g]  = chain[STAGES-1] & ~prev;
    end
  endgenerate

endmodule

// File: rtl/kbd_tx_timer.sv
module kbd_tx_timer #(
  parameter int unsigned LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);

  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] tmr_next(input logic [W-1:0] c);
    return (c == W'(LIMIT - 1)) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || kick) cnt <= '0;
    else                   cnt <= tmr_next(cnt);
  end

  assign expire = run && !kick && (cnt == W'(LIMIT - 1));

  // R7
  expire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/kbd_tx_shifter.sv
module kbd_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              advance,
  output logic              cur_bit,
  output logic              last
);

  localparam int FRAME = DATA_W + 1;
  localparam int IW    = $clog2(FRAME);

  logic [FRAME-1:0] frame;
  logic [IW-1:0]    idx;

  // Data first (bit 0 at the bottom), odd parity on top
  function automatic logic [FRAME-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {~(^d), d};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      idx   <= '0;
    end else if (load) begin
      frame <= build_frame(load_data);
      idx   <= '0;
    end else if (advance && !last) begin
      frame <= frame >> 1;
      idx   <= idx + 1'b1;
    end
  end

  assign cur_bit = frame[0];
  assign last    = (idx == IW'(FRAME - 1));

endmodule

// File: rtl/kbd_host_tx.sv
module kbd_host_tx
  import kbd_tx_pkg::*;
#(
  parameter int          DATA_W         = 8,
  parameter int          SYNC_STAGES    = 2,
  parameter int unsigned TIMEOUT_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              tx_error,
  input  logic              kb_clk_in,
  input  logic              kb_data_in,
  output logic              kb_clk_pull,
  output logic              kb_data_pull
);

  tx_state_e state_q, state_d;

  logic [LANES-1:0] lvl, rise_v;
  logic c_lvl, c_rise, d_lvl, d_rise;
  logic accept_evt, advance_evt, progress_evt, abort_evt, ack_evt;
  logic cur_bit, last_bit, tmr_expire;

  kbd_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LANES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({kb_data_in, kb_clk_in}),
    .level    (lvl),
    .rise     (rise_v)
  );

  assign c_lvl  = lvl[LANE_CLK];
  assign c_rise = rise_v[LANE_CLK];
  assign d_lvl  = lvl[LANE_DAT];
  assign d_rise = rise_v[LANE_DAT];

  kbd_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_evt),
    .load_data (tx_data),
    .advance   (advance_evt),
    .cur_bit   (cur_bit),
    .last      (last_bit)
  );

  kbd_tx_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q != ST_IDLE),
    .kick   (progress_evt),
    .expire (tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (tx_valid)           state_d = ST_REQ;
      ST_REQ:      if (d_rise)             state_d = ST_START;
      ST_START:    if (c_rise)             state_d = ST_BITS;
      ST_BITS:     if (c_rise && last_bit) state_d = ST_STOP_REL;
      ST_STOP_REL: if (d_lvl)              state_d = ST_STOP_ACK;
      ST_STOP_ACK: if (!d_lvl)             state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  assign accept_evt   = tx_valid && (state_q == ST_IDLE);
  assign advance_evt  = (state_q == ST_BITS) && c_rise && !last_bit;
  assign progress_evt = (state_d != state_q) || advance_evt;
  assign abort_evt    = tmr_expire;
  assign ack_evt      = (state_q == ST_STOP_ACK) && !d_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= ST_IDLE;
    else if (abort_evt) state_q <= ST_IDLE;
    else                state_q <= state_d;
  end

  assign tx_ready     = (state_q == ST_IDLE);
  assign tx_done      = ack_evt;
  assign tx_error     = abort_evt;
  assign kb_clk_pull  = (state_q == ST_REQ);
  assign kb_data_pull = (state_q == ST_BITS) && !cur_bit;

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!kb_clk_pull && !kb_data_pull));

  // R2
  accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (kb_clk_pull && !tx_ready));

  // R3
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kb_clk_pull) |-> ($past(d_rise) || $past(abort_evt)));

  // R4
  data_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(kb_data_pull) |-> ($past(c_rise) || $past(abort_evt)));

  // R4
  pull_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kb_data_pull) |-> c_lvl);

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (tx_ready && !kb_data_pull && !tx_done));

  // R7
  err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_error |=> (tx_ready && !kb_clk_pull && !kb_data_pull));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, tx_error}));

endmodule

// File: tb/tb_kbd_host_tx.sv
`timescale 1ns/1ps
module tb_kbd_host_tx;

  localparam int TO       = 100;
  localparam int START_LEN = 40;
  localparam int HI_LEN   = 12;
  localparam int LO_LEN   = 8;

  // {expected parity, byte}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h01}, {1'b1, 8'hA5},
    {1'b0, 8'h80}, {1'b1, 8'h7E}, {1'b0, 8'h13}, {1'b1, 8'h3C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, tx_done, tx_error, kb_clk_pull, kb_data_pull;
  logic kbd_pc = 1'b0;   // keyboard pulling clock low
  logic kbd_pd = 1'b1;   // keyboard pulling data low (idle data is low)
  logic kb_clk_in, kb_data_in;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign kb_clk_in  = ~(kb_clk_pull | kbd_pc);
  assign kb_data_in = ~(kb_data_pull | kbd_pd);

  kbd_host_tx #(.TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_error(tx_error),
    .kb_clk_in(kb_clk_in), .kb_data_in(kb_data_in),
    .kb_clk_pull(kb_clk_pull), .kb_data_pull(kb_data_pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    check(kb_clk_pull && !tx_ready, "R2 request after accept",
          {kb_clk_pull, tx_ready}, 2);
    tx_valid = 1'b0;
  endtask

  // keyboard answers the request and holds the start bit
  task automatic answer_request;
    int waited;
    repeat (4) @(negedge clk);
    check(kb_clk_pull == 1'b1, "R3 clock held before data rise", kb_clk_pull, 1);
    kbd_pd = 1'b0;
    kbd_pc = 1'b1;
    waited = 0;
    while (kb_clk_pull && waited < 10) begin
      @(negedge clk);
      waited++;
    end
    check(!kb_clk_pull && waited >= 2 && waited <= 4, "R3 release latency", waited, 3);
    repeat (START_LEN) @(negedge clk);
  endtask

  task automatic clock_bit(output logic sampled, input bit poke, input logic [7:0] other);
    kbd_pc = 1'b0;
    repeat (HI_LEN) @(negedge clk);
    if (poke) begin
      tx_data  = other;
      tx_valid = 1'b1;
      @(negedge clk);
      check(!tx_ready, "R9 busy ignores valid", tx_ready, 0);
      tx_valid = 1'b0;
    end
    kbd_pc = 1'b1;
    repeat (4) @(negedge clk);
    sampled = kb_data_in;
    repeat (LO_LEN - 4) @(negedge clk);
  endtask

  task automatic do_frame(input logic [7:0] d, input logic p, input bit poke);
    logic [8:0] got;
    int dn, er;
    check(tx_ready, "R1 ready before frame", tx_ready, 1);
    offer(d);
    answer_request();
    for (int i = 0; i < 9; i++) begin
      logic b;
      clock_bit(b, poke && (i == 4), ~d);
      got[i] = b;
    end
    kbd_pc = 1'b0;
    repeat (6) @(negedge clk);
    check(kb_data_in == 1'b1, "R6 data released after tenth rise", kb_data_in, 1);
    kbd_pd = 1'b1;
    dn = 0;
    er = 0;
    repeat (8) begin
      @(negedge clk);
      dn += int'(tx_done);
      er += int'(tx_error);
    end
    check(got[7:0] == d, "R4 bits lsb first", got[7:0], d);
    check(got[8] == p, "R5 odd parity", got[8], p);
    check(dn == 1, "R6 single done", dn, 1);
    check(er == 0, "R8 no error on success", er, 0);
    check(tx_ready && !kb_clk_pull && !kb_data_pull, "R1 idle after frame",
          {tx_ready, kb_clk_pull, kb_data_pull}, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    logic b;
    repeat (3) @(negedge clk);
    check(tx_ready && !kb_clk_pull && !kb_data_pull && !tx_done && !tx_error,
          "R1 reset state", {tx_ready, kb_clk_pull, kb_data_pull, tx_done, tx_error}, 16);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_ready && !kb_clk_pull, "R1 idle after reset", {tx_ready, kb_clk_pull}, 2);

    for (int v = 0; v < 8; v++) begin
      do_frame(VEC[v][7:0], VEC[v][8], 1'b0);
      repeat (5) @(negedge clk);
    end

    // R9: byte offered mid-frame must not disturb the one in flight
    do_frame(8'hC6, 1'b1, 1'b1);
    repeat (5) @(negedge clk);

    // R7: keyboard never answers the request
    @(negedge clk);
    tx_data  = 8'h42;
    tx_valid = 1'b1;
    k = 0;
    while (k < 3 * TO) begin
      @(negedge clk);
      tx_valid = 1'b0;
      k++;
      if (tx_error) break;
    end
    check(k >= TO - 2 && k <= TO + 2, "R7 timeout window on request", k, TO);
    @(negedge clk);
    check(tx_ready && !kb_clk_pull && !kb_data_pull && !tx_error,
          "R7 lines released after abort", {tx_ready, kb_clk_pull, kb_data_pull, tx_error}, 8);

    // R7: keyboard stalls after three bits (0x00 keeps data pulled low)
    offer(8'h00);
    answer_request();
    for (int i = 0; i < 3; i++) clock_bit(b, 1'b0, 8'h00);
    kbd_pc = 1'b0;
    check(kb_data_pull == 1'b1, "R4 zero bit pulls data", kb_data_pull, 1);
    k = 0;
    while (k < 3 * TO && !tx_error) begin
      @(negedge clk);
      k++;
    end
    check(tx_error == 1'b1 && k <= TO + 20, "R7 timeout mid frame", k, TO);
    @(negedge clk);
    check(!tx_error && !kb_data_pull && tx_ready, "R8 error single pulse and release",
          {tx_error, kb_data_pull, tx_ready}, 1);
    kbd_pd = 1'b1;
    repeat (5) @(negedge clk);

    // R7: normal transfer after abort
    do_frame(8'h5A, 1'b1, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule